// File: doc/BRIEF.md
# I2C Target Interface with Acknowledge-Phase Clock Stretching

This block is the target (slave) side of an I2C bus, clocked by a fast system clock that oversamples the two bus lines. It recognises START and STOP conditions and compares the first byte of each transfer against a configurable 7-bit address. On a match it exchanges data bytes with the bus master in either direction. The bus pins are modelled as open-drain: the block only ever pulls a line low through a drive-low enable, and it observes the resolved line level on a sampled input.

Local logic connects through two byte channels with valid/ready handshakes. A byte written by the master is offered on the write channel. A byte for the master to read is requested on the read channel. Before each acknowledge slot where the local side has to act, the block holds SCL low until the handshake completes. The master therefore never runs ahead of the local logic. A busy flag is high while the block is addressed.

Top module: `i2c_stretch_target`

## Requirements
- R1: After reset both drive-low enables are 0, `busy` is 0, `wrValid` is 0 and `rdReady` is 0.
- R2: After the two-flop synchronizer and glitch filter, a START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A STOP returns the block to idle with `busy` low.
- R3: The first byte after a START is sent MSB first: 7 address bits, then a direction bit (1 = master reads, 0 = master writes). When the address equals `ownAddr`, the block pulls SDA low during the ninth clock as an ACK, and `busy` goes high.
- R4: With a non-matching address the block leaves both lines released and raises neither `wrValid` nor `rdReady` until the next START.
- R5: In a write transfer, each received byte is presented MSB-first on `wrData` with `wrValid` high, and stays stable until `wrReady`. From the falling SCL edge that ends the eighth bit until the handshake, SCL is held low. The block then ACKs the byte.
- R6: In a read transfer, after the read address the block holds SCL low with `rdReady` high until `rdValid`, then ACKs. It shifts the byte out MSB first and pulls SDA low only while SCL is low.
- R7: After each read byte the block releases SDA and samples the master's bit on the ninth clock. An ACK (SDA low) starts a new stretched request for the next byte. A NACK (SDA high) ends the transfer: SDA stays released, no further `rdReady` is raised and `busy` falls.
- R8: A repeated START at any point restarts address reception. A new direction can then be selected without an intervening STOP.
- R9: A START or STOP in the middle of a byte abandons that byte. The partial byte is never offered on `wrData`, and both lines are released.
- R10: A pulse on SDA shorter than `FILT_LEN` system clocks is ignored and does not create a START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| ownAddr | input | 7 | Address the block answers to |
| sclIn | input | 1 | Resolved SCL line level |
| sdaIn | input | 1 | Resolved SDA line level |
| sclDriveLow | output | 1 | 1 pulls SCL low (clock stretch) |
| sdaDriveLow | output | 1 | 1 pulls SDA low |
| wrData | output | 8 | Byte written by the master |
| wrValid | output | 1 | `wrData` holds a received byte |
| wrReady | input | 1 | Local side takes the received byte |
| rdData | input | 8 | Byte to send to the master |
| rdValid | input | 1 | `rdData` is loaded |
| rdReady | output | 1 | Block requests a byte to send |
| busy | output | 1 | Block is addressed and in a transfer |

## Verification
Writes are run with a slow local responder. The SCL low time seen by the master at the acknowledge slot then grows with the responder delay, which separates real stretching from plain pacing by the master. A read of three bytes, ACK, ACK, NACK, followed by an extra clocked byte, separates stopping on a NACK from continuing. A mismatched address, an SDA glitch with no START, a repeated START in the middle of a byte and a STOP in the middle of a byte each check that the block stays off the bus or drops the partial byte. A clean write after each of these shows that the block recovers.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_IGNORE,
    ST_WR_DATA,
    ST_WR_HOLD,
    ST_WR_ACK,
    ST_RD_LOAD_A,
    ST_RD_LOAD,
    ST_RD_DATA,
    ST_RD_ACK,
    ST_RD_END
  } tgtState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic takeBit;   // shift SDA into receive register, count bit
    logic clrCnt;    // restart bit counter
    logic loadTx;    // capture rdData into transmit register
    logic shiftTx;   // advance transmit register by one bit
  } dpCtl_t;

endpackage

// File: rtl/i2c_tgt_filter.sv
module i2c_tgt_filter #(
  parameter int LEN = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic cleanOut
);
  logic [1:0]     syncQ;
  logic [LEN-1:0] histQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= '1;
      histQ    <= '1;
      cleanOut <= 1'b1;
    end else begin
      syncQ <= {syncQ[0], rawIn};
      histQ <= {histQ[LEN-2:0], syncQ[1]};
      if (&histQ)       cleanOut <= 1'b1;
      else if (~|histQ) cleanOut <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_tgt_datapath.sv
module i2c_tgt_datapath
  import i2c_tgt_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int FILT_LEN = 3,
  localparam int CNT_W   = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpCtl_t            dpCtl,
  input  logic [BYTE_W-1:0] rdData,
  output logic              sclF,
  output logic              sdaF,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startDet,
  output logic              stopDet,
  output logic              byteDone,
  output logic [BYTE_W-1:0] rxByte,
  output logic              txMsb,
  output logic              txNext
);
  logic [1:0] rawLines, cleanLines;
  logic sclP, sdaP;
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] txShift;

  assign rawLines = {sdaIn, sclIn};

  for (genvar g = 0; g < 2; g++) begin : gLine
    i2c_tgt_filter #(.LEN(FILT_LEN)) uFilt (
      .clk(clk), .rstN(rstN), .rawIn(rawLines[g]), .cleanOut(cleanLines[g])
    );
  end

  assign sclF = cleanLines[0];
  assign sdaF = cleanLines[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclP <= 1'b1;
      sdaP <= 1'b1;
    end else begin
      sclP <= sclF;
      sdaP <= sdaF;
    end
  end

  assign sclRise  = sclF & ~sclP;
  assign sclFall  = ~sclF & sclP;
  assign startDet = sclF & sclP & sdaP & ~sdaF;
  assign stopDet  = sclF & sclP & ~sdaP & sdaF;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      rxByte  <= '0;
      txShift <= '1;
    end else begin
      if (dpCtl.clrCnt)       bitCnt <= '0;
      else if (dpCtl.takeBit) bitCnt <= bitCnt + 1'b1;
      if (dpCtl.takeBit) rxByte <= {rxByte[BYTE_W-2:0], sdaF};
      if (dpCtl.loadTx)       txShift <= rdData;
      else if (dpCtl.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b1};
    end
  end

  assign byteDone = (bitCnt == CNT_W'(BYTE_W));
  assign txMsb    = txShift[BYTE_W-1];
  assign txNext   = txShift[BYTE_W-2];

  // bit counter never runs past a full byte
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    byteDone |=> (bitCnt <= CNT_W'(BYTE_W)));
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter int BYTE_W   = 8,
  localparam int ADDR_W  = BYTE_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              sclF,
  input  logic              sdaF,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic              byteDone,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              txMsb,
  input  logic              txNext,
  input  logic              wrReady,
  input  logic              rdValid,
  input  logic              rdMsb,
  output dpCtl_t            dpCtl,
  output logic              sclDriveLow,
  output logic              sdaDriveLow,
  output logic              wrValid,
  output logic              rdReady,
  output logic              busy
);
  tgtState_e state;
  logic rwQ, ackQ, addrHit, holdState;

  assign addrHit   = (rxByte[BYTE_W-1:1] == ownAddr);
  assign holdState = state inside {ST_WR_HOLD, ST_RD_LOAD_A, ST_RD_LOAD};
  assign wrValid   = (state == ST_WR_HOLD);
  assign rdReady   = state inside {ST_RD_LOAD_A, ST_RD_LOAD};
  assign busy      = !(state inside {ST_IDLE, ST_ADDR, ST_IGNORE, ST_RD_END});

  always_comb begin
    dpCtl.takeBit = sclRise && (state inside {ST_ADDR, ST_WR_DATA, ST_RD_DATA});
    dpCtl.clrCnt  = startDet
                  || (sclFall && (state inside {ST_ADDR_ACK, ST_WR_ACK}))
                  || (state == ST_RD_LOAD && rdValid);
    dpCtl.loadTx  = rdReady && rdValid;
    dpCtl.shiftTx = sclFall && (state == ST_RD_DATA) && !byteDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      sdaDriveLow <= 1'b0;
      sclDriveLow <= 1'b0;
      rwQ         <= 1'b0;
      ackQ        <= 1'b0;
    end else begin
      // SCL hold trails the state by one cycle: SDA settles before release
      sclDriveLow <= holdState;
      if (stopDet) begin
        state       <= ST_IDLE;
        sdaDriveLow <= 1'b0;
      end else if (startDet) begin
        state       <= ST_ADDR;
        sdaDriveLow <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: if (sclFall && byteDone) begin
            if (addrHit) begin
              rwQ <= rxByte[0];
              if (rxByte[0]) state <= ST_RD_LOAD_A;
              else begin
                state       <= ST_ADDR_ACK;
                sdaDriveLow <= 1'b1;
              end
            end else state <= ST_IGNORE;
          end
          ST_ADDR_ACK: if (sclFall) begin
            sdaDriveLow <= rwQ ? ~txMsb : 1'b0;
            state       <= rwQ ? ST_RD_DATA : ST_WR_DATA;
          end
          ST_WR_DATA: if (sclFall && byteDone) state <= ST_WR_HOLD;
          ST_WR_HOLD: if (wrReady) begin
            state       <= ST_WR_ACK;
            sdaDriveLow <= 1'b1;
          end
          ST_WR_ACK: if (sclFall) begin
            state       <= ST_WR_DATA;
            sdaDriveLow <= 1'b0;
          end
          ST_RD_LOAD_A: if (rdValid) begin
            state       <= ST_ADDR_ACK;
            sdaDriveLow <= 1'b1;
          end
          ST_RD_LOAD: if (rdValid) begin
            state       <= ST_RD_DATA;
            sdaDriveLow <= ~rdMsb;
          end
          ST_RD_DATA: if (sclFall) begin
            if (byteDone) begin
              state       <= ST_RD_ACK;
              sdaDriveLow <= 1'b0;
            end else sdaDriveLow <= ~txNext;
          end
          ST_RD_ACK: begin
            if (sclRise) ackQ <= ~sdaF;
            if (sclFall) state <= ackQ ? ST_RD_LOAD : ST_RD_END;
          end
          default: ;
        endcase
      end
    end
  end

  // R4: outside a matched transfer neither line is pulled
  p_quiet_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy)) |-> (!sclDriveLow && !sdaDriveLow));
  // R5: a pending write byte keeps SCL held
  p_stretch_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid || rdReady) |=> sclDriveLow);
  // R5: offered byte stays until taken
  p_wr_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> (wrValid && $stable(rxByte)));
  // R6: read request persists until served
  p_rd_wait_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rdReady && !rdValid && !startDet && !stopDet) |=> rdReady);
  // R6: SDA is only pulled low during the SCL low phase
  p_sda_low_phase_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDriveLow) |-> !sclF);
  // R5: a stretch only begins while SCL is already low
  p_hold_low_phase_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclDriveLow) |-> !sclF);
endmodule

// File: rtl/i2c_stretch_target.sv
module i2c_stretch_target
  import i2c_tgt_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int FILT_LEN = 3,
  localparam int ADDR_W  = BYTE_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclDriveLow,
  output logic              sdaDriveLow,
  output logic [BYTE_W-1:0] wrData,
  output logic              wrValid,
  input  logic              wrReady,
  input  logic [BYTE_W-1:0] rdData,
  input  logic              rdValid,
  output logic              rdReady,
  output logic              busy
);
  dpCtl_t dpCtl;
  logic sclF, sdaF, sclRise, sclFall, startDet, stopDet, byteDone, txMsb, txNext;

  i2c_tgt_datapath #(.BYTE_W(BYTE_W), .FILT_LEN(FILT_LEN)) uDp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .dpCtl(dpCtl),
    .rdData(rdData), .sclF(sclF), .sdaF(sdaF), .sclRise(sclRise),
    .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet),
    .byteDone(byteDone), .rxByte(wrData), .txMsb(txMsb), .txNext(txNext)
  );

  i2c_tgt_ctrl #(.BYTE_W(BYTE_W)) uCtrl (
    .clk(clk), .rstN(rstN), .ownAddr(ownAddr), .sclF(sclF), .sdaF(sdaF),
    .sclRise(sclRise), .sclFall(sclFall), .startDet(startDet),
    .stopDet(stopDet), .byteDone(byteDone), .rxByte(wrData), .txMsb(txMsb),
    .txNext(txNext), .wrReady(wrReady), .rdValid(rdValid),
    .rdMsb(rdData[BYTE_W-1]), .dpCtl(dpCtl), .sclDriveLow(sclDriveLow),
    .sdaDriveLow(sdaDriveLow), .wrValid(wrValid), .rdReady(rdReady),
    .busy(busy)
  );
endmodule

// File: tb/sim_i2c_stretch_target.sv
`timescale 1ns/1ps
module sim_i2c_stretch_target;
  localparam int Q = 12;
  logic clk = 1'b0, rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1, glitchN = 1'b1;
  logic sclIn, sdaIn, sclDriveLow, sdaDriveLow, wrValid, rdReady, busy;
  logic wrReady = 1'b0, rdValid = 1'b0;
  logic [7:0] wrData, rdData = 8'h00;
  int checks = 0, errors = 0;
  int wrDelay = 0, rdDelay = 0, wrWait = 0, rdWait = 0;
  int wrCount = 0, rdIdx = 0, rdReqCnt = 0, driveSeen = 0;
  logic rdPrev = 1'b0;
  logic [7:0] wrLog [16];
  logic [7:0] rdQ [8];

  always #2.5 clk = ~clk;

  assign sclIn = sclM & ~sclDriveLow;
  assign sdaIn = sdaM & ~sdaDriveLow & glitchN;

  i2c_stretch_target u0 (
    .clk(clk), .rstN(rstN), .ownAddr(7'h2A), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow), .wrData(wrData),
    .wrValid(wrValid), .wrReady(wrReady), .rdData(rdData), .rdValid(rdValid),
    .rdReady(rdReady), .busy(busy)
  );

  // local-side responder
  always @(negedge clk) begin
    if (wrValid) begin
      if (!wrReady) begin
        if (wrWait >= wrDelay) begin
          wrReady = 1'b1;
          wrLog[wrCount] = wrData;
          wrCount++;
        end else wrWait++;
      end
    end else begin
      wrReady = 1'b0;
      wrWait  = 0;
    end
    if (rdReady) begin
      if (!rdValid) begin
        if (rdWait >= rdDelay) begin
          rdValid = 1'b1;
          rdData  = rdQ[rdIdx];
        end else rdWait++;
      end
    end else begin
      if (rdValid) rdIdx++;
      rdValid = 1'b0;
      rdWait  = 0;
    end
    if (rdReady && !rdPrev) rdReqCnt++;
    rdPrev = rdReady;
    if (sclDriveLow || sdaDriveLow) driveSeen++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sclPulse(output logic bitOut, output int stretch);
    waitCyc(Q);
    sclM = 1'b1;
    stretch = 0;
    do begin
      waitCyc(1);
      stretch++;
    end while (!sclIn && stretch < 3000);
    waitCyc(Q);
    bitOut = sdaIn;
    sclM = 1'b0;
  endtask

  task automatic busStart();
    waitCyc(2); sdaM = 1'b1;
    waitCyc(Q); sclM = 1'b1;
    waitCyc(Q); sdaM = 1'b0;
    waitCyc(Q); sclM = 1'b0;
  endtask

  task automatic busStop();
    waitCyc(2); sdaM = 1'b0;
    waitCyc(Q); sclM = 1'b1;
    waitCyc(Q); sdaM = 1'b1;
    waitCyc(Q);
  endtask

  task automatic writeBit(input logic b);
    logic dummy;
    int st;
    waitCyc(2);
    sdaM = b;
    sclPulse(dummy, st);
  endtask

  task automatic writeByte(input logic [7:0] b, output logic ack, output int st9);
    logic a;
    for (int i = 7; i >= 0; i--) writeBit(b[i]);
    waitCyc(2);
    sdaM = 1'b1;
    sclPulse(a, st9);
    ack = !a;
  endtask

  task automatic readByte(input logic giveAck, output logic [7:0] v);
    logic b;
    int st;
    for (int i = 0; i < 8; i++) begin
      waitCyc(2);
      sdaM = 1'b1;
      sclPulse(b, st);
      v = {v[6:0], b};
    end
    waitCyc(2);
    sdaM = !giveAck;
    sclPulse(b, st);
    waitCyc(2);
    sdaM = 1'b1;
  endtask

  task automatic t_reset();
    chk("R1 sclDriveLow", sclDriveLow, 0);
    chk("R1 sdaDriveLow", sdaDriveLow, 0);
    chk("R1 busy", busy, 0);
    chk("R1 wrValid", wrValid, 0);
    chk("R1 rdReady", rdReady, 0);
  endtask

  task automatic t_write();
    logic ack;
    int st0, st1;
    wrDelay = 40;
    busStart();
    writeByte(8'h54, ack, st0);
    chk("R3 write address ack", ack, 1);
    chk("R3 busy after match", busy, 1);
    writeByte(8'hA5, ack, st0);
    chk("R5 data ack 1", ack, 1);
    chk("R5 stretch length", st0 > 20, 1);
    wrDelay = 0;
    writeByte(8'h3C, ack, st1);
    chk("R5 data ack 2", ack, 1);
    chk("R5 short stretch below long", st1 < st0, 1);
    busStop();
    waitCyc(10);
    chk("R5 byte count", wrCount, 2);
    chk("R5 byte 0", wrLog[0], 8'hA5);
    chk("R5 byte 1", wrLog[1], 8'h3C);
    chk("R2 busy after stop", busy, 0);
  endtask

  task automatic t_read();
    logic ack;
    logic [7:0] v;
    int st;
    rdDelay = 30;
    rdReqCnt = 0;
    busStart();
    writeByte(8'h55, ack, st);
    chk("R3 read address ack", ack, 1);
    chk("R6 stretch before address ack", st > 20, 1);
    readByte(1'b1, v);
    chk("R6 read byte 0", v, 8'h96);
    readByte(1'b1, v);
    chk("R7 read byte 1 after ack", v, 8'h5A);
    readByte(1'b0, v);
    chk("R7 read byte 2", v, 8'hF0);
    waitCyc(10);
    chk("R7 busy after nack", busy, 0);
    readByte(1'b0, v);
    chk("R7 sda released after nack", v, 8'hFF);
    chk("R7 request count", rdReqCnt, 3);
    busStop();
  endtask

  task automatic t_unmatched();
    logic ack;
    int st;
    driveSeen = 0;
    busStart();
    writeByte(8'h26, ack, st);
    chk("R4 no ack on mismatch", ack, 0);
    writeByte(8'h00, ack, st);
    chk("R4 no ack on data", ack, 0);
    busStop();
    chk("R4 lines never driven", driveSeen, 0);
    chk("R4 no write byte", wrCount, 2);
  endtask

  task automatic t_restart();
    logic ack;
    logic [7:0] v;
    int st;
    busStart();
    writeByte(8'h54, ack, st);
    chk("R8 first address ack", ack, 1);
    writeBit(1'b1); writeBit(1'b0); writeBit(1'b1); writeBit(1'b1);
    busStart();
    writeByte(8'h55, ack, st);
    chk("R8 ack after repeated start", ack, 1);
    readByte(1'b0, v);
    chk("R8 read after repeated start", v, 8'hC3);
    busStop();
    chk("R9 partial byte dropped on start", wrCount, 2);
  endtask

  task automatic t_stop_abort();
    logic ack;
    int st;
    busStart();
    writeByte(8'h54, ack, st);
    writeBit(1'b0); writeBit(1'b1); writeBit(1'b1);
    busStop();
    waitCyc(10);
    chk("R9 busy after mid-byte stop", busy, 0);
    chk("R9 lines released", sclDriveLow | sdaDriveLow, 0);
    chk("R9 partial byte dropped on stop", wrCount, 2);
    busStart();
    writeByte(8'h54, ack, st);
    writeByte(8'h81, ack, st);
    busStop();
    chk("R9 recovery write", wrLog[2], 8'h81);
  endtask

  task automatic t_glitch();
    logic ack;
    int st;
    driveSeen = 0;
    waitCyc(Q);
    glitchN = 1'b0;
    waitCyc(1);
    glitchN = 1'b1;
    waitCyc(Q);
    sclM = 1'b0;
    writeByte(8'h54, ack, st);
    chk("R10 glitch gave no start", ack, 0);
    chk("R10 no drive after glitch", driveSeen, 0);
    busStop();
    chk("R2 idle after glitch", busy, 0);
  endtask

  initial begin
    rdQ[0] = 8'h96; rdQ[1] = 8'h5A; rdQ[2] = 8'hF0; rdQ[3] = 8'hC3;
    rdQ[4] = 8'h11; rdQ[5] = 8'h22; rdQ[6] = 8'h33; rdQ[7] = 8'h44;
    waitCyc(5);
    t_reset();
    rstN = 1'b1;
    waitCyc(20);
    t_reset();
    t_write();
    t_read();
    t_unmatched();
    t_restart();
    t_stop_abort();
    t_glitch();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule